// File: doc/BRIEF.md
# Per-Target Request Arbiter with Locked Ownership

This block sits in front of one slave port of a crossbar interconnect. Each slave port has its own copy, so masters that target different slaves never contend. The block arbitrates only among the masters that request this one slave in the same cycle. Each master drives three signals into it: a request line, a lock line, and a strobe that marks the end of its current transaction. The block returns a one-hot grant and a flag that says whether the grant is valid.

When the target is free, the block picks a requester by fixed priority, with master 0 highest. The owner then keeps the grant until it pulses its end strobe. The lock line is sampled together with that strobe. If lock is high at that moment, no arbitration happens and the same master keeps the slave for its next transaction. This holds even if a higher-priority master is waiting. If lock is low, the block arbitrates again in the same cycle among the current requests, and the owner may win again.

Top module: `tgt_lock_arbiter`

## Requirements
- R1: After reset, `gnt_o` is all zeros and `gnt_vld_o` is low.
- R2: When no master owns the target and at least one `req_i` bit is high at a clock edge, then after that edge `gnt_vld_o` is high and `gnt_o` has exactly bit i set. Here i is the lowest-numbered requesting master: bit i of every vector belongs to master i, and master 0 has the highest priority.
- R3: `gnt_o` never has more than one bit set, and `gnt_vld_o` is high exactly when `gnt_o` is non-zero.
- R4: While a master owns the target, `gnt_o` stays unchanged at every edge where the owner's `done_i` bit is low. Requests, lock bits and done bits of other masters have no effect on it.
- R5: At an edge where the owner's `done_i` bit is high and its `lock_i` bit is low, the block arbitrates again by the R2 priority among the `req_i` bits of that cycle. The owner may win again.
- R6: At an edge where the owner's `done_i` and `lock_i` bits are both high, the grant stays with the owner, even when a higher-priority master is requesting.
- R7: A `lock_i` bit from a master that does not own the grant has no effect on the outcome at the owner's end strobe.
- R8: When the target is free and no `req_i` bit is high, `gnt_vld_o` stays low and `gnt_o` stays zero. The same holds after an unlocked end strobe with no requests pending.
- R9: When several masters request together, the lowest-numbered one wins. For example, masters 0 and 3 requesting together give `gnt_o` = 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MST | Request line per master |
| lock_i | input | N_MST | Lock line per master, sampled with its end strobe |
| done_i | input | N_MST | End-of-transaction strobe per master |
| gnt_o | output | N_MST | One-hot grant, bit i for master i |
| gnt_vld_o | output | 1 | High while some master holds the grant |

## Verification
The directed scenarios check that a locked end strobe keeps the grant even while master 0 is waiting. A design that ignored lock would hand the slave to master 0 there. They check that end strobes and lock bits from non-owners do nothing. A design that OR-reduced those vectors without masking them by the owner would release the grant or freeze it at the wrong time. They check that an owner which asks again after an unlocked end competes on plain priority. They also check that an end strobe with no pending requests clears the valid flag. A design that did not clear it would leave a stale owner in place.

// File: rtl/tla_pkg.sv
package tla_pkg;
   typedef enum logic {
      OWN_FREE = 1'b0,
      OWN_HELD = 1'b1
   } own_state_e;

   localparam int unsigned TLA_MAX_MST = 32;
endpackage

// File: rtl/tla_prio_pick.sv
// Fixed-priority picker, lowest index wins. The variant is chosen by parameter.
module tla_prio_pick #(
   parameter int unsigned N         = 4,
   parameter bit          USE_CHAIN = 1'b1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick,
   output logic         any
);
   assign any = |req;

   generate
      if (USE_CHAIN) begin : g_chain
         // ripple of "someone below already won"
         logic [N:0] seen;
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
         end
      end else begin : g_twos
         // isolate lowest set bit with two's complement
         logic [N-1:0] neg;
         assign neg  = ~req + {{(N-1){1'b0}}, 1'b1};
         assign pick = req & neg;
      end
   endgenerate
endmodule

// File: rtl/tla_owner_match.sv
// Qualifies the per-master end and lock strobes by the current owner.
module tla_owner_match #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] owner,
   input  logic [N-1:0] done_v,
   input  logic [N-1:0] lock_v,
   output logic         end_hit,
   output logic         lock_hit
);
   logic [N-1:0] end_sel;
   logic [N-1:0] lock_sel;

   generate
      for (genvar i = 0; i < N; i++) begin : g_m
         assign end_sel[i]  = owner[i] & done_v[i];
         assign lock_sel[i] = end_sel[i] & lock_v[i];
      end
   endgenerate

   assign end_hit  = |end_sel;
   assign lock_hit = |lock_sel;
endmodule

// File: rtl/tla_owner_reg.sv
// Holds the current owner and whether the target is taken.
module tla_owner_reg
   import tla_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arb_open,
   input  logic [N-1:0] pick,
   input  logic         any,
   output logic [N-1:0] owner,
   output own_state_e   state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner <= '0;
         state <= OWN_FREE;
      end else if (arb_open) begin
         if (any) begin
            owner <= pick;
            state <= OWN_HELD;
         end else begin
            owner <= '0;
            state <= OWN_FREE;
         end
      end
   end
endmodule

// File: rtl/tgt_lock_arbiter.sv
module tgt_lock_arbiter
   import tla_pkg::*;
#(
   parameter int unsigned N_MST      = 4,
   parameter bit          PICK_CHAIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MST-1:0] req_i,
   input  logic [N_MST-1:0] lock_i,
   input  logic [N_MST-1:0] done_i,
   output logic [N_MST-1:0] gnt_o,
   output logic             gnt_vld_o
);
   generate
      if (N_MST < 2 || N_MST > TLA_MAX_MST) begin : g_bad_n
         $error("tgt_lock_arbiter: N_MST out of range");
      end
   endgenerate

   logic [N_MST-1:0] pick;
   logic             any_req;
   logic [N_MST-1:0] owner;
   own_state_e       state;
   logic             end_hit;
   logic             lock_hit;
   logic             arb_open;

   tla_prio_pick #(.N(N_MST), .USE_CHAIN(PICK_CHAIN)) u_pick (
      .req  (req_i),
      .pick (pick),
      .any  (any_req)
   );

   tla_owner_match #(.N(N_MST)) u_match (
      .owner    (owner),
      .done_v   (done_i),
      .lock_v   (lock_i),
      .end_hit  (end_hit),
      .lock_hit (lock_hit)
   );

   // free target, or owner ending without lock
   assign arb_open = (state == OWN_FREE) | (end_hit & ~lock_hit);

   tla_owner_reg #(.N(N_MST)) u_own (
      .clk      (clk),
      .rst_n    (rst_n),
      .arb_open (arb_open),
      .pick     (pick),
      .any      (any_req),
      .owner    (owner),
      .state    (state)
   );

   assign gnt_o     = owner;
   assign gnt_vld_o = (state == OWN_HELD);
endmodule

// File: rtl/tla_checker.sv
module tla_checker #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] req_i,
   input logic [N-1:0] lock_i,
   input logic [N-1:0] done_i,
   input logic [N-1:0] gnt_o,
   input logic         gnt_vld_o
);
   logic owner_end;
   logic owner_lock;
   logic opening;
   assign owner_end  = |(done_i & gnt_o);
   assign owner_lock = |(done_i & gnt_o & lock_i);
   assign opening    = !gnt_vld_o || (owner_end && !owner_lock);

   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));
   p_vld_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o == (gnt_o != '0));
   p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_vld_o && (req_i != '0)) |=> gnt_vld_o);
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && !owner_end) |=> ($stable(gnt_o) && gnt_vld_o));
   p_lock_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && owner_lock) |=> ($stable(gnt_o) && gnt_vld_o));
   p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (opening && (req_i != '0)) |=>
         (gnt_o == ($past(req_i) & (~$past(req_i) + {{(N-1){1'b0}}, 1'b1}))));
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (opening && (req_i == '0)) |=> !gnt_vld_o);
endmodule

bind tgt_lock_arbiter tla_checker #(.N(N_MST)) u_tla_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .lock_i    (lock_i),
   .done_i    (done_i),
   .gnt_o     (gnt_o),
   .gnt_vld_o (gnt_vld_o)
);

// File: tb/tgt_lock_arbiter_tb_top.sv
module tgt_lock_arbiter_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_i = '0;
   logic [N-1:0] lock_i = '0;
   logic [N-1:0] done_i = '0;
   logic [N-1:0] gnt_o;
   logic         gnt_vld_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tgt_lock_arbiter #(.N_MST(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
      .done_i(done_i), .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o)
   );

   task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l,
                        input logic [N-1:0] d);
      req_i = r; lock_i = l; done_i = d;
   endtask

   // one edge passes, sample at following negedge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [N-1:0] eg, input logic ev);
      n_chk++;
      if (gnt_o !== eg || gnt_vld_o !== ev) begin
         n_bad++;
         $display("FAIL %s: gnt=%b vld=%b expected gnt=%b vld=%b",
                  tag, gnt_o, gnt_vld_o, eg, ev);
      end
   endtask

   task automatic release_all();
      drive('0, '0, '1); step();
      drive('0, '0, '0); chk("R8 release", 4'b0000, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 reset", 4'b0000, 1'b0);
      rst_n = 1'b1; step();
      chk("R1 after reset no req", 4'b0000, 1'b0);
   endtask

   task automatic t_single();
      drive(4'b0100, '0, '0); step();
      chk("R2 single request", 4'b0100, 1'b1);
      drive(4'b0000, '0, '0); step();
      chk("R4 owner drops req keeps grant", 4'b0100, 1'b1);
      drive(4'b0000, '0, 4'b0100); step();
      chk("R8 unlocked end, no req", 4'b0000, 1'b0);
      drive('0, '0, '0);
   endtask

   task automatic t_tie();
      drive(4'b1001, '0, '0); step();
      chk("R9 tie 0 vs 3", 4'b0001, 1'b1);
      drive(4'b1001, '0, 4'b0001); step();
      chk("R5 owner re-wins on priority", 4'b0001, 1'b1);
      drive(4'b1000, '0, 4'b0001); step();
      chk("R5 handover to master 3", 4'b1000, 1'b1);
      drive('0, '0, '0);
      release_all();
   endtask

   task automatic t_hold();
      drive(4'b0100, '0, '0); step();
      chk("R2 take by master 2", 4'b0100, 1'b1);
      drive(4'b0001, 4'b0011, 4'b1011); step();
      chk("R4 non-owner strobes ignored", 4'b0100, 1'b1);
      drive(4'b0011, 4'b1111, 4'b0000); step();
      chk("R4 lock without end ignored", 4'b0100, 1'b1);
      drive(4'b0011, 4'b0000, 4'b0100); step();
      chk("R5 rearbitrate to master 0", 4'b0001, 1'b1);
      drive('0, '0, '0);
      release_all();
   endtask

   task automatic t_lock();
      drive(4'b1000, '0, '0); step();
      chk("R2 low-priority owner", 4'b1000, 1'b1);
      drive(4'b0001, 4'b1000, 4'b1000); step();
      chk("R6 locked end keeps grant", 4'b1000, 1'b1);
      drive(4'b0011, 4'b1000, 4'b1000); step();
      chk("R6 second locked end", 4'b1000, 1'b1);
      drive(4'b0011, 4'b0000, 4'b1000); step();
      chk("R5 unlock hands to master 0", 4'b0001, 1'b1);
      drive('0, '0, '0);
      release_all();
   endtask

   task automatic t_lock_nonowner();
      drive(4'b0010, '0, '0); step();
      chk("R2 take by master 1", 4'b0010, 1'b1);
      drive(4'b0001, 4'b0001, 4'b0010); step();
      chk("R7 foreign lock ignored", 4'b0001, 1'b1);
      drive('0, '0, '0);
      release_all();
   endtask

   task automatic t_idle();
      drive('0, 4'b1111, 4'b1111); step();
      chk("R8 idle with strobes", 4'b0000, 1'b0);
      drive('0, '0, '0); step();
      chk("R8 idle quiet", 4'b0000, 1'b0);
      drive(4'b1110, '0, '0); step();
      chk("R2 three requesters", 4'b0010, 1'b1);
      drive('0, '0, '0);
      release_all();
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_single();
      t_tie();
      t_hold();
      t_lock();
      t_lock_nonowner();
      t_idle();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule